// File: doc/BRIEF.md
# Superpage and Invalid-Entry Translation Cache

This block is a small, register-based, fully associative cache that sits beside the set-associative levels of a second-level translation cache. It keeps two kinds of entries: leaf entries for large pages, and upper-level entries found to be invalid. Each entry carries a 2-bit translation type, so host tables, first-stage (guest) tables and second-stage (guest-physical) tables can share the store without aliasing. A lookup presents a virtual page number with a type, an address-space ID and a VM ID. Three cycles later the cache answers with hit or miss and, on a hit, the physical page number, the permission bits, the level and the prefetch flag of the entry.

Entries are written by refill strobes from the page walkers. The victim is the lowest free slot, or else the slot chosen by a binary pseudo-LRU tree. Fence operations clear the valid bit of every entry they select, in one cycle. The selection depends on the fence kind, the virtualization mode, the address, the ASID and the VMID, and a zero operand acts as a wildcard.

Top module: `superpage_entry_cache`

## Requirements
- R1: A lookup strobed in cycle 0 produces `respValid` high in cycle 3 only, one response per request; `respValid` is low in cycles 1 and 2.
- R2: After reset no entry is valid: every lookup misses and `respValid` is low until a lookup is made.
- R3: Type codes are 00 host, 01 first-stage only, 10 second-stage only, 11 both stages. An entry matches only a lookup of its own type, and a type-11 lookup matches type-01 entries only.
- R4: ASID takes no part in matching when the effective lookup type is 10. VMID takes no part in matching when it is 00. An entry whose G permission bit is set matches any ASID.
- R5: An entry of level L (0, 1 or 2) ignores the low 9*L bits of the 27-bit page number. On a hit the outputs carry the stored PPN, prefetch flag, level and permissions, with the permissions ordered [6]D [5]A [4]G [3]U [2]X [1]W [0]R.
- R6: A refill goes to the lowest-numbered invalid entry when one exists, so no valid entry is displaced.
- R7: When all entries are valid, a refill replaces the tree pseudo-LRU victim. The written entry becomes most recently used, and so does an entry hit in cycle 3.
- R8: Fence kind 00 with the virtualization input low clears host (00) entries. A nonzero address must match under the entry's level. A nonzero ASID must equal the entry's ASID, and entries with G set survive an ASID-specific fence.
- R9: Fence kind 00 with the virtualization input high clears type-01 entries. It applies the same address and ASID rules as R8, and the entry's VMID must equal the fence VMID.
- R10: Fence kind 01 clears type-01 entries and kind 10 clears type-10 entries, selected by address and VMID, each wildcarded when zero. Kind 11 clears nothing, and no fence affects entries of another type.
- R11: A response that misses drives PPN, permissions, level and prefetch as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookValid | input | 1 | Lookup strobe |
| lookVpn | input | 27 | Lookup virtual page number |
| lookType | input | 2 | Lookup translation type |
| lookAsid | input | 16 | Lookup address-space ID |
| lookVmid | input | 14 | Lookup VM ID |
| fillValid | input | 1 | Refill strobe |
| fillVpn | input | 27 | Refill page number |
| fillType | input | 2 | Refill translation type |
| fillAsid | input | 16 | Refill address-space ID |
| fillVmid | input | 14 | Refill VM ID |
| fillPpn | input | 24 | Refill physical page number |
| fillPerm | input | 7 | Refill permissions D A G U X W R |
| fillLevel | input | 2 | Refill level |
| fillPrefetch | input | 1 | Refill came from a prefetch |
| fenceValid | input | 1 | Fence strobe |
| fenceKind | input | 2 | Fence kind |
| fenceVirt | input | 1 | Virtualization mode for kind 00 |
| fenceAddr | input | 27 | Fence address, zero means all |
| fenceAsid | input | 16 | Fence ASID, zero means all |
| fenceVmid | input | 14 | Fence VMID |
| respValid | output | 1 | Response strobe |
| respHit | output | 1 | Response hit |
| respPpn | output | 24 | Hit physical page number |
| respPerm | output | 7 | Hit permissions |
| respLevel | output | 2 | Hit level |
| respPrefetch | output | 1 | Hit prefetch flag |

## Verification
Lookups are driven with page numbers that differ only in the bits a superpage ignores and with page numbers that differ just above them, which separates correct level masking from an over- or under-wide mask. Lookups that are repeated with each type code, with foreign ASIDs and VMIDs, and with G set or clear show whether every matching qualifier is applied or skipped as required. Fences of each kind are followed by a sweep over every key ever stored, so an over-broad fence and a missed clear both show up. Full-cache refills after chosen hit orders show whether the replacement tree picked the right victim. A seeded random mix of refills, lookups and fences over a small key space then compares every response with a bench model.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [1:0] {
    XL_HOST = 2'b00,
    XL_VS   = 2'b01,
    XL_G    = 2'b10,
    XL_BOTH = 2'b11
  } xlType_e;

  typedef enum logic [1:0] {
    FK_SFENCE   = 2'b00,
    FK_HFENCE_VS = 2'b01,
    FK_HFENCE_G  = 2'b10,
    FK_NONE     = 2'b11
  } fenceKind_e;

  localparam int PERM_W     = 7;
  localparam int PERM_BIT_G = 4;

  typedef struct packed {
    logic load1;
    logic load2;
    logic load3;
    logic present;
    logic fillEn;
    logic flushEn;
  } spcStrobes_t;
endpackage

// File: rtl/spc_control.sv
module spc_control
  import spc_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookValid,
  input  logic                   fillValid,
  input  logic                   fenceValid,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] hitVec,
  output spcStrobes_t            strobes,
  output logic [IDX_W-1:0]       fillIdx,
  output logic                   respValid,
  output logic                   respHit
);
  localparam int TREE_W = NUM_ENTRIES - 1;

  logic v1, v2, v3;
  logic [TREE_W-1:0] tree, treeNext;
  logic [IDX_W-1:0] hitWay, firstFree;
  logic anyFree, hitAny;

  function automatic logic [IDX_W-1:0] plruVictim(input logic [TREE_W-1:0] t);
    int node = 0;
    for (int l = 0; l < IDX_W; l++) node = 2 * node + 1 + int'(t[node]);
    return IDX_W'(node - TREE_W);
  endfunction

  function automatic logic [TREE_W-1:0] plruTouch(input logic [TREE_W-1:0] t,
                                                  input logic [IDX_W-1:0] way);
    logic [TREE_W-1:0] r = t;
    int node = 0;
    logic dir;
    for (int l = 0; l < IDX_W; l++) begin
      dir = way[IDX_W-1-l];
      r[node] = ~dir;
      node = 2 * node + 1 + int'(dir);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      tree <= '0;
    end else begin
      v1 <= lookValid;
      v2 <= v1;
      v3 <= v2;
      tree <= treeNext;
    end
  end

  always_comb begin
    hitWay = '0;
    firstFree = '0;
    anyFree = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) hitWay = IDX_W'(i);
      if (!validVec[i]) begin
        firstFree = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign hitAny  = v3 && (|hitVec);
  assign fillIdx = anyFree ? firstFree : plruVictim(tree);

  always_comb begin
    treeNext = tree;
    if (hitAny) treeNext = plruTouch(treeNext, hitWay);
    if (fillValid) treeNext = plruTouch(treeNext, fillIdx);
  end

  assign strobes.load1   = lookValid;
  assign strobes.load2   = v1;
  assign strobes.load3   = v2;
  assign strobes.present = v3;
  assign strobes.fillEn  = fillValid;
  assign strobes.flushEn = fenceValid;

  assign respValid = v3;
  assign respHit   = hitAny;
endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int LVL_BITS = 9,
  parameter int NUM_LEVELS = 3,
  parameter int PPN_W = 24,
  parameter int ASID_W = 16,
  parameter int VMID_W = 14,
  parameter int IDX_W = $clog2(NUM_ENTRIES),
  parameter int VPN_W = LVL_BITS * NUM_LEVELS,
  parameter int LEVEL_W = $clog2(NUM_LEVELS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  spcStrobes_t            strobes,
  input  logic [IDX_W-1:0]       fillIdx,
  input  logic [VPN_W-1:0]       lookVpn,
  input  logic [1:0]             lookType,
  input  logic [ASID_W-1:0]      lookAsid,
  input  logic [VMID_W-1:0]      lookVmid,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [1:0]             fillType,
  input  logic [ASID_W-1:0]      fillAsid,
  input  logic [VMID_W-1:0]      fillVmid,
  input  logic [PPN_W-1:0]       fillPpn,
  input  logic [PERM_W-1:0]      fillPerm,
  input  logic [LEVEL_W-1:0]     fillLevel,
  input  logic                   fillPrefetch,
  input  logic [1:0]             fenceKind,
  input  logic                   fenceVirt,
  input  logic [VPN_W-1:0]       fenceAddr,
  input  logic [ASID_W-1:0]      fenceAsid,
  input  logic [VMID_W-1:0]      fenceVmid,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] hitVec,
  output logic [PPN_W-1:0]       respPpn,
  output logic [PERM_W-1:0]      respPerm,
  output logic [LEVEL_W-1:0]     respLevel,
  output logic                   respPrefetch
);
  // entry store
  logic [NUM_ENTRIES-1:0] eValid, validNext;
  logic [VPN_W-1:0]   eVpn  [NUM_ENTRIES];
  logic [1:0]         eType [NUM_ENTRIES];
  logic [ASID_W-1:0]  eAsid [NUM_ENTRIES];
  logic [VMID_W-1:0]  eVmid [NUM_ENTRIES];
  logic [PPN_W-1:0]   ePpn  [NUM_ENTRIES];
  logic [PERM_W-1:0]  ePerm [NUM_ENTRIES];
  logic [LEVEL_W-1:0] eLvl  [NUM_ENTRIES];
  logic               ePf   [NUM_ENTRIES];

  // lookup pipeline
  logic [VPN_W-1:0]  s1Vpn, s2Vpn;
  logic [1:0]        s1Type, s2Type;
  logic [ASID_W-1:0] s1Asid, s2Asid;
  logic [VMID_W-1:0] s1Vmid, s2Vmid;
  logic [NUM_ENTRIES-1:0] matchVec, flushVec, s3Match;
  logic [PPN_W-1:0]   s3Ppn, selPpn;
  logic [PERM_W-1:0]  s3Perm, selPerm;
  logic [LEVEL_W-1:0] s3Lvl, selLvl;
  logic               s3Pf, selPf;
  logic [1:0] effType, fenceTarget;
  logic       fenceTargetOk, fenceIsS, s3Hit;

  function automatic logic vpnHit(input logic [VPN_W-1:0] a, input logic [VPN_W-1:0] b,
                                  input logic [LEVEL_W-1:0] lvl);
    logic [VPN_W-1:0] m;
    for (int k = 0; k < VPN_W; k++) m[k] = (k >= int'(lvl) * LVL_BITS);
    return ((a ^ b) & m) == '0;
  endfunction

  assign effType = (s2Type == XL_BOTH) ? XL_VS : s2Type;
  assign fenceIsS = (fenceKind == FK_SFENCE);

  always_comb begin
    fenceTargetOk = 1'b1;
    case (fenceKind)
      FK_SFENCE:    fenceTarget = fenceVirt ? XL_VS : XL_HOST;
      FK_HFENCE_VS: fenceTarget = XL_VS;
      FK_HFENCE_G:  fenceTarget = XL_G;
      default: begin
        fenceTarget = XL_HOST;
        fenceTargetOk = 1'b0;
      end
    endcase
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic asidOk, vmidOk, fAddr, fAsid, fVmid;
    assign asidOk = (effType == XL_G) || (eAsid[i] == s2Asid) || ePerm[i][PERM_BIT_G];
    assign vmidOk = (effType == XL_HOST) || (eVmid[i] == s2Vmid);
    assign matchVec[i] = eValid[i] && (eType[i] == effType) && asidOk && vmidOk
                         && vpnHit(eVpn[i], s2Vpn, eLvl[i]);
    assign fAddr = (fenceAddr == '0) || vpnHit(eVpn[i], fenceAddr, eLvl[i]);
    assign fAsid = !fenceIsS || (fenceAsid == '0)
                   || ((eAsid[i] == fenceAsid) && !ePerm[i][PERM_BIT_G]);
    assign fVmid = fenceIsS ? (!fenceVirt || (eVmid[i] == fenceVmid))
                            : ((fenceVmid == '0) || (eVmid[i] == fenceVmid));
    assign flushVec[i] = eValid[i] && fenceTargetOk && (eType[i] == fenceTarget)
                         && fAddr && fAsid && fVmid;
  end

  always_comb begin
    validNext = eValid;
    if (strobes.flushEn) validNext = validNext & ~flushVec;
    if (strobes.fillEn) validNext[fillIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) eValid <= '0;
    else eValid <= validNext;
  end

  always_ff @(posedge clk) begin
    if (strobes.fillEn) begin
      eVpn[fillIdx]  <= fillVpn;
      eType[fillIdx] <= fillType;
      eAsid[fillIdx] <= fillAsid;
      eVmid[fillIdx] <= fillVmid;
      ePpn[fillIdx]  <= fillPpn;
      ePerm[fillIdx] <= fillPerm;
      eLvl[fillIdx]  <= fillLevel;
      ePf[fillIdx]   <= fillPrefetch;
    end
  end

  // lowest matching index wins
  always_comb begin
    logic [IDX_W-1:0] sel;
    sel = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) if (matchVec[i]) sel = IDX_W'(i);
    selPpn  = ePpn[sel];
    selPerm = ePerm[sel];
    selLvl  = eLvl[sel];
    selPf   = ePf[sel];
  end

  always_ff @(posedge clk) begin
    if (strobes.load1) begin
      s1Vpn <= lookVpn;  s1Type <= lookType;
      s1Asid <= lookAsid; s1Vmid <= lookVmid;
    end
    if (strobes.load2) begin
      s2Vpn <= s1Vpn;  s2Type <= s1Type;
      s2Asid <= s1Asid; s2Vmid <= s1Vmid;
    end
    if (strobes.load3) begin
      s3Match <= matchVec;
      s3Ppn <= selPpn; s3Perm <= selPerm;
      s3Lvl <= selLvl; s3Pf <= selPf;
    end
  end

  assign s3Hit        = strobes.present && (|s3Match);
  assign validVec     = eValid;
  assign hitVec       = strobes.present ? s3Match : '0;
  assign respPpn      = s3Hit ? s3Ppn : '0;
  assign respPerm     = s3Hit ? s3Perm : '0;
  assign respLevel    = s3Hit ? s3Lvl : '0;
  assign respPrefetch = s3Hit && s3Pf;
endmodule

// File: rtl/superpage_entry_cache.sv
module superpage_entry_cache
  import spc_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int LVL_BITS = 9,
  parameter int NUM_LEVELS = 3,
  parameter int PPN_W = 24,
  parameter int ASID_W = 16,
  parameter int VMID_W = 14,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int VPN_W = LVL_BITS * NUM_LEVELS,
  localparam int LEVEL_W = $clog2(NUM_LEVELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookValid,
  input  logic [VPN_W-1:0]   lookVpn,
  input  logic [1:0]         lookType,
  input  logic [ASID_W-1:0]  lookAsid,
  input  logic [VMID_W-1:0]  lookVmid,
  input  logic               fillValid,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [1:0]         fillType,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [VMID_W-1:0]  fillVmid,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [PERM_W-1:0]  fillPerm,
  input  logic [LEVEL_W-1:0] fillLevel,
  input  logic               fillPrefetch,
  input  logic               fenceValid,
  input  logic [1:0]         fenceKind,
  input  logic               fenceVirt,
  input  logic [VPN_W-1:0]   fenceAddr,
  input  logic [ASID_W-1:0]  fenceAsid,
  input  logic [VMID_W-1:0]  fenceVmid,
  output logic               respValid,
  output logic               respHit,
  output logic [PPN_W-1:0]   respPpn,
  output logic [PERM_W-1:0]  respPerm,
  output logic [LEVEL_W-1:0] respLevel,
  output logic               respPrefetch
);
  spcStrobes_t strobes;
  logic [IDX_W-1:0] fillIdx;
  logic [NUM_ENTRIES-1:0] validVec, hitVec;

  spc_control #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lookValid(lookValid), .fillValid(fillValid),
    .fenceValid(fenceValid), .validVec(validVec), .hitVec(hitVec),
    .strobes(strobes), .fillIdx(fillIdx), .respValid(respValid), .respHit(respHit)
  );

  spc_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .LVL_BITS(LVL_BITS), .NUM_LEVELS(NUM_LEVELS),
    .PPN_W(PPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W),
    .IDX_W(IDX_W), .VPN_W(VPN_W), .LEVEL_W(LEVEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fillIdx(fillIdx),
    .lookVpn(lookVpn), .lookType(lookType), .lookAsid(lookAsid), .lookVmid(lookVmid),
    .fillVpn(fillVpn), .fillType(fillType), .fillAsid(fillAsid), .fillVmid(fillVmid),
    .fillPpn(fillPpn), .fillPerm(fillPerm), .fillLevel(fillLevel),
    .fillPrefetch(fillPrefetch), .fenceKind(fenceKind), .fenceVirt(fenceVirt),
    .fenceAddr(fenceAddr), .fenceAsid(fenceAsid), .fenceVmid(fenceVmid),
    .validVec(validVec), .hitVec(hitVec), .respPpn(respPpn), .respPerm(respPerm),
    .respLevel(respLevel), .respPrefetch(respPrefetch)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int PPN_W = 24,
  parameter int PERM_W = 7,
  parameter int LEVEL_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               lookValid,
  input logic               fillValid,
  input logic               respValid,
  input logic               respHit,
  input logic [PPN_W-1:0]   respPpn,
  input logic [PERM_W-1:0]  respPerm,
  input logic [LEVEL_W-1:0] respLevel,
  input logic               respPrefetch
);
  logic [2:0] lookHist;
  logic fillSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookHist <= '0;
      fillSeen <= 1'b0;
    end else begin
      lookHist <= {lookHist[1:0], lookValid};
      if (fillValid) fillSeen <= 1'b1;
    end
  end

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    respValid == lookHist[2]);  // R1
  AST_HIT_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);  // R1
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respPpn == '0 && respPerm == '0 && respLevel == '0 && !respPrefetch));  // R11
  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !fillSeen |-> !respHit);  // R2
endmodule

bind superpage_entry_cache spc_checker #(
  .PPN_W(PPN_W), .PERM_W(spc_pkg::PERM_W), .LEVEL_W(LEVEL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .lookValid(lookValid), .fillValid(fillValid),
  .respValid(respValid), .respHit(respHit), .respPpn(respPpn), .respPerm(respPerm),
  .respLevel(respLevel), .respPrefetch(respPrefetch)
);

// File: tb/superpage_entry_cache_bench.sv
module superpage_entry_cache_bench;
  localparam int NE = 16, LB = 9, VW = 27, PW = 24, AW = 16, MW = 14, LW = 2;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic lookValid = 0; logic [VW-1:0] lookVpn = '0; logic [1:0] lookType = '0;
  logic [AW-1:0] lookAsid = '0; logic [MW-1:0] lookVmid = '0;
  logic fillValid = 0; logic [VW-1:0] fillVpn = '0; logic [1:0] fillType = '0;
  logic [AW-1:0] fillAsid = '0; logic [MW-1:0] fillVmid = '0; logic [PW-1:0] fillPpn = '0;
  logic [6:0] fillPerm = '0; logic [LW-1:0] fillLevel = '0; logic fillPrefetch = 0;
  logic fenceValid = 0; logic [1:0] fenceKind = '0; logic fenceVirt = 0;
  logic [VW-1:0] fenceAddr = '0; logic [AW-1:0] fenceAsid = '0; logic [MW-1:0] fenceVmid = '0;
  logic respValid, respHit, respPrefetch;
  logic [PW-1:0] respPpn; logic [6:0] respPerm; logic [LW-1:0] respLevel;

  superpage_entry_cache u_superpage_entry_cache (
    .clk(clk), .rstN(rstN), .lookValid(lookValid), .lookVpn(lookVpn), .lookType(lookType),
    .lookAsid(lookAsid), .lookVmid(lookVmid), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillType(fillType), .fillAsid(fillAsid), .fillVmid(fillVmid), .fillPpn(fillPpn),
    .fillPerm(fillPerm), .fillLevel(fillLevel), .fillPrefetch(fillPrefetch),
    .fenceValid(fenceValid), .fenceKind(fenceKind), .fenceVirt(fenceVirt),
    .fenceAddr(fenceAddr), .fenceAsid(fenceAsid), .fenceVmid(fenceVmid),
    .respValid(respValid), .respHit(respHit), .respPpn(respPpn), .respPerm(respPerm),
    .respLevel(respLevel), .respPrefetch(respPrefetch)
  );

  // bench model
  bit mV[NE]; bit mW[NE];
  logic [VW-1:0] mVpn[NE]; logic [1:0] mTy[NE]; logic [AW-1:0] mAs[NE];
  logic [MW-1:0] mVm[NE]; logic [PW-1:0] mPpn[NE]; logic [6:0] mPm[NE];
  logic [LW-1:0] mLv[NE]; bit mPf[NE];
  bit mTree[NE-1];
  int errors = 0, checks = 0;
  bit done = 0;

  function automatic logic [VW-1:0] mMask(input logic [LW-1:0] lvl);
    logic [VW-1:0] m;
    for (int b = 0; b < VW; b++) m[b] = (b >= int'(lvl) * LB);
    return m;
  endfunction

  function automatic int mFind(logic [VW-1:0] vpn, logic [1:0] ty, logic [AW-1:0] asid,
                               logic [MW-1:0] vmid);
    logic [1:0] eff = (ty == 2'b11) ? 2'b01 : ty;
    for (int i = 0; i < NE; i++)
      if (mV[i] && ((mVpn[i] ^ vpn) & mMask(mLv[i])) == '0 && mTy[i] == eff
          && (eff == 2'b10 || mAs[i] == asid || mPm[i][4])
          && (eff == 2'b00 || mVm[i] == vmid)) return i;
    return -1;
  endfunction

  function automatic void mTouch(int way);
    int node = 0;
    for (int l = 3; l >= 0; l--) begin
      int dir = (way >> l) & 1;
      mTree[node] = (dir == 0);
      node = 2 * node + 1 + dir;
    end
  endfunction

  function automatic int mVictim();
    int node = 0;
    for (int i = 0; i < NE; i++) if (!mV[i]) return i;
    for (int l = 0; l < 4; l++) node = 2 * node + 1 + int'(mTree[node]);
    return node - (NE - 1);
  endfunction

  function automatic void mClear();
    for (int i = 0; i < NE; i++) begin mV[i] = 0; mW[i] = 0; end
    for (int i = 0; i < NE - 1; i++) mTree[i] = 0;
  endfunction

  function automatic void mFence(int kind, bit virt, logic [VW-1:0] addr,
                                 logic [AW-1:0] asid, logic [MW-1:0] vmid);
    for (int i = 0; i < NE; i++) begin
      int tgt; bit ok, aOk, sOk, vOk;
      ok = 1;
      case (kind)
        0: tgt = virt ? 1 : 0;
        1: tgt = 1;
        2: tgt = 2;
        default: begin tgt = 0; ok = 0; end
      endcase
      aOk = (addr == '0) || (((mVpn[i] ^ addr) & mMask(mLv[i])) == '0);
      sOk = (kind != 0) || (asid == '0) || (mAs[i] == asid && !mPm[i][4]);
      vOk = (kind == 0) ? (!virt || mVm[i] == vmid) : (vmid == '0 || mVm[i] == vmid);
      if (mV[i] && ok && int'(mTy[i]) == tgt && aOk && sOk && vOk) mV[i] = 0;
    end
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    mClear();
  endtask

  task automatic doLookup(logic [VW-1:0] vpn, logic [1:0] ty, logic [AW-1:0] asid,
                          logic [MW-1:0] vmid, string req);
    int idx; bit early; bit ok;
    logic [PW-1:0] ePpn; logic [6:0] ePerm; logic [LW-1:0] eLv; bit ePf;
    idx = mFind(vpn, ty, asid, vmid);
    ePpn = (idx >= 0) ? mPpn[idx] : '0; ePerm = (idx >= 0) ? mPm[idx] : '0;
    eLv = (idx >= 0) ? mLv[idx] : '0; ePf = (idx >= 0) ? mPf[idx] : 0;
    @(negedge clk);
    lookValid = 1; lookVpn = vpn; lookType = ty; lookAsid = asid; lookVmid = vmid;
    @(posedge clk);
    @(negedge clk); lookValid = 0; early = respValid;
    @(posedge clk);
    @(negedge clk); early = early | respValid;
    @(posedge clk);
    @(negedge clk);
    checks++;
    ok = !early && respValid && (respHit == (idx >= 0)) && respPpn == ePpn
         && respPerm == ePerm && respLevel == eLv && respPrefetch == ePf;
    if (!ok) begin
      errors++;
      $display("FAIL %s vpn=%h type=%0d: got early=%0b valid=%0b hit=%0b ppn=%h perm=%b lvl=%0d pf=%0b, expected early=0 valid=1 hit=%0b ppn=%h perm=%b lvl=%0d pf=%0b",
               req, vpn, ty, early, respValid, respHit, respPpn, respPerm, respLevel,
               respPrefetch, idx >= 0, ePpn, ePerm, eLv, ePf);
    end
    if (idx >= 0) mTouch(idx);
  endtask

  task automatic doFill(logic [VW-1:0] vpn, logic [1:0] ty, logic [AW-1:0] asid,
                        logic [MW-1:0] vmid, logic [PW-1:0] ppn, logic [6:0] perm,
                        logic [LW-1:0] lvl, bit pf);
    int v;
    @(negedge clk);
    fillValid = 1; fillVpn = vpn; fillType = ty; fillAsid = asid; fillVmid = vmid;
    fillPpn = ppn; fillPerm = perm; fillLevel = lvl; fillPrefetch = pf;
    v = mVictim();
    mV[v] = 1; mW[v] = 1; mVpn[v] = vpn; mTy[v] = ty; mAs[v] = asid; mVm[v] = vmid;
    mPpn[v] = ppn; mPm[v] = perm; mLv[v] = lvl; mPf[v] = pf;
    mTouch(v);
    @(posedge clk);
    @(negedge clk); fillValid = 0;
  endtask

  task automatic doFence(int kind, bit virt, logic [VW-1:0] addr, logic [AW-1:0] asid,
                         logic [MW-1:0] vmid);
    @(negedge clk);
    fenceValid = 1; fenceKind = 2'(kind); fenceVirt = virt;
    fenceAddr = addr; fenceAsid = asid; fenceVmid = vmid;
    mFence(kind, virt, addr, asid, vmid);
    @(posedge clk);
    @(negedge clk); fenceValid = 0;
  endtask

  // looks up the key of every slot ever written
  task automatic sweep(string req);
    for (int i = 0; i < NE; i++)
      if (mW[i]) doLookup(mVpn[i], mTy[i], mAs[i], mVm[i], req);
  endtask

  function automatic logic [VW-1:0] mk(int a, int b, int c);
    return {9'(a), 9'(b), 9'(c)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    doReset();
    // R2: idle and empty after reset
    checks++;
    if (respValid !== 1'b0) begin
      errors++; $display("FAIL R2 reset: got respValid=%0b expected 0", respValid);
    end
    doLookup(mk(1, 2, 3), 2'b00, 16'd1, 14'd0, "R2 R11 empty miss");

    // R5 superpage masking and fields
    doFill(mk(3, 7, 11), 2'b00, 16'd5, 14'd0, 24'hABCDE, 7'b1100011, 2'd2, 1);
    doLookup(mk(3, 100, 200), 2'b00, 16'd5, 14'd0, "R5 1G hit low bits differ");
    doLookup(mk(4, 7, 11), 2'b00, 16'd5, 14'd0, "R5 1G miss high bits differ");
    doFill(mk(1, 2, 3), 2'b00, 16'd5, 14'd0, 24'h12345, 7'b0101010, 2'd1, 0);
    doLookup(mk(1, 2, 400), 2'b00, 16'd5, 14'd0, "R5 2M hit");
    doLookup(mk(1, 3, 3), 2'b00, 16'd5, 14'd0, "R5 2M miss");

    // R3 type matching
    doFill(mk(6, 6, 6), 2'b01, 16'd2, 14'd9, 24'h00606, 7'b0000011, 2'd0, 0);
    doLookup(mk(6, 6, 6), 2'b11, 16'd2, 14'd9, "R3 both-stage hits VS");
    doLookup(mk(6, 6, 6), 2'b01, 16'd2, 14'd9, "R3 VS hit");
    doLookup(mk(6, 6, 6), 2'b00, 16'd2, 14'd9, "R3 host misses VS");
    doLookup(mk(6, 6, 6), 2'b01, 16'd2, 14'd8, "R4 VS vmid mismatch");

    // R4 qualifiers
    doFill(mk(8, 8, 8), 2'b10, 16'd1, 14'd3, 24'h00808, 7'b0011111, 2'd0, 1);
    doLookup(mk(8, 8, 8), 2'b10, 16'd77, 14'd3, "R4 G ignores asid");
    doLookup(mk(8, 8, 8), 2'b10, 16'd1, 14'd4, "R4 G vmid mismatch");
    doLookup(mk(3, 7, 11), 2'b00, 16'd5, 14'd55, "R4 host ignores vmid");
    doFill(mk(9, 9, 9), 2'b00, 16'd12, 14'd0, 24'h00909, 7'b0010011, 2'd0, 0);
    doLookup(mk(9, 9, 9), 2'b00, 16'd13, 14'd0, "R4 global ignores asid");

    // R8 host fences
    doFence(0, 0, '0, 16'd5, '0);
    sweep("R8 asid fence");
    doFence(0, 0, mk(9, 9, 9), '0, '0);
    sweep("R8 addr fence");
    // R9 virtualized fence
    doFence(0, 1, '0, '0, 14'd8);
    sweep("R9 vmid mismatch keeps");
    doFence(0, 1, '0, '0, 14'd9);
    sweep("R9 vmid match clears");
    // R10 hfence variants
    doFill(mk(6, 6, 6), 2'b01, 16'd2, 14'd9, 24'h00707, 7'b0000011, 2'd0, 0);
    doFence(3, 0, '0, '0, '0);
    sweep("R10 kind 11 no effect");
    doFence(2, 0, mk(8, 8, 8), '0, '0);
    sweep("R10 G fence");
    doFence(1, 0, '0, '0, 14'd9);
    sweep("R10 VS fence");

    // R6 free slot first
    doReset();
    for (int i = 0; i < NE; i++)
      doFill(mk(0, 0, i), 2'b00, 16'd1, 14'd0, 24'(i + 16), 7'b0000011, 2'd0, 0);
    doFence(0, 0, mk(0, 0, 5), '0, '0);
    doFill(mk(0, 1, 0), 2'b00, 16'd1, 14'd0, 24'h00FFF, 7'b0000011, 2'd0, 0);
    sweep("R6 free slot reused");
    // R7 pseudo-LRU victims
    doLookup(mk(0, 0, 2), 2'b00, 16'd1, 14'd0, "R7 touch");
    doLookup(mk(0, 0, 9), 2'b00, 16'd1, 14'd0, "R7 touch");
    for (int k = 0; k < 3; k++) begin
      doFill(mk(0, 2, k), 2'b00, 16'd1, 14'd0, 24'(k + 100), 7'b0000011, 2'd0, 0);
      sweep("R7 victim order");
    end

    // random mix
    doReset();
    for (int n = 0; n < 500; n++) begin
      int r = $urandom % 10;
      logic [VW-1:0] v = mk($urandom % 2, $urandom % 2, $urandom % 4);
      if (r < 3)
        doFill(v, 2'($urandom % 3), 16'($urandom % 3), 14'($urandom % 3),
               24'($urandom), 7'($urandom), 2'($urandom % 3), 1'($urandom));
      else if (r < 9)
        doLookup(v, 2'($urandom % 4), 16'($urandom % 3), 14'($urandom % 3), "R3 R4 R5 R7 random");
      else
        doFence($urandom % 4, 1'($urandom), ($urandom % 3 == 0) ? '0 : v,
                16'($urandom % 3), 14'($urandom % 3));
    end
    sweep("R8 R9 R10 random final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule